// File: doc/BRIEF.md
# Self-ID Gap Count Agreement Checker

During bus initialisation every node broadcasts a self-identification packet that carries its gap count setting. This block watches the gap-count field of each such packet as it is received. It decides whether all nodes reported the same value. The field is presented with a valid strobe by an upstream packet parser. The block remembers the first value seen after a bus reset as its reference and compares every later value against it. It keeps a running "disagreement seen" state.

When the end-of-self-ID indication rises, the block freezes its verdict into two diagnostic outputs: a disagreement flag and a common gap count. The common gap count carries the agreed value only when every received value was identical, and is zero otherwise. After the freeze, further strobes are ignored until the next bus reset, which clears the reference, the running state and both outputs.

Top module: `gapcnt_agree_chk`

## Requirements
- R1: While `rst_n` is low (asynchronous), `disagree_o` is 0 and `common_gap_o` is 0.
- R2: When every strobed gap value since the last bus reset equals the first one, the freeze sets `disagree_o` to 0 and `common_gap_o` to that value.
- R3: When any strobed gap value differs from the first one since the last bus reset, the freeze sets `disagree_o` to 1 and `common_gap_o` to 0.
- R4: The freeze happens on the clock edge at which `sid_done_i` is first sampled high after being sampled low. The outputs show the new verdict from that edge on and keep their old value before it.
- R5: A freeze with no strobe since the last bus reset gives `disagree_o` = 0 and `common_gap_o` = 0.
- R6: After a freeze and until the next bus reset, strobes and further rising edges of `sid_done_i` leave both outputs unchanged.
- R7: A clock edge with `bus_reset_i` high clears both outputs, the reference and the disagreement state. It takes priority over a strobe or a `sid_done_i` rising edge in the same cycle, and that edge causes no freeze.
- R8: A strobe sampled on the same edge as the `sid_done_i` rising edge is included in the frozen verdict.
- R9: Between bus reset and freeze the outputs stay at 0 while strobes are being accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | Bus reset; clears all state on a clock edge |
| sid_valid_i | input | 1 | Strobe: `sid_gap_i` holds a received gap count |
| sid_gap_i | input | GAP_W (6) | Gap-count field of the received self-ID packet |
| sid_done_i | input | 1 | End-of-self-ID level; its rising edge freezes the verdict |
| disagree_o | output | 1 | Frozen flag: received gap counts were not all equal |
| common_gap_o | output | GAP_W (6) | Frozen agreed gap count, or 0 |

## Verification
Two pairs of functions can land on one clock edge. A gap strobe can coincide with the end-of-self-ID rising edge, and a bus reset can coincide with that rising edge. The bench provokes the first by presenting a matching and then a differing last value together with the rising edge, and expects the last value to decide the verdict. For the second it raises bus reset and the end level together over a frozen nonzero verdict. It expects cleared outputs, then no freeze while the level stays high, and a clean freeze with the later strobe once the level has fallen and risen again.

// File: rtl/gce_pkg.sv
package gce_pkg;

   // running comparison state kept between bus reset and freeze
   typedef struct packed {
      logic seen;    // a reference value has been captured
      logic differ;  // some value differed from the reference
   } gce_track_t;

   localparam int GCE_MAX_W = 32;

endpackage

// File: rtl/gce_edge.sv
module gce_edge #(
   parameter bit LEVEL_IN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic fire_o
);

   generate
      if (LEVEL_IN) begin : g_level
         logic sig_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sig_q <= 1'b0;
            else        sig_q <= sig_i;
         end
         assign fire_o = sig_i & ~sig_q;
      end else begin : g_pulse
         assign fire_o = sig_i;
      end
   endgenerate

endmodule

// File: rtl/gce_track.sv
module gce_track
   import gce_pkg::*;
#(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         hold_i,
   input  logic         vld_i,
   input  logic [W-1:0] gap_i,
   output logic [W-1:0] ref_nx_o,
   output gce_track_t   st_nx_o
);

   logic [W-1:0] ref_q;
   gce_track_t   st_q;

   always_comb begin
      ref_nx_o = ref_q;
      st_nx_o  = st_q;
      if (vld_i && !hold_i) begin
         if (!st_q.seen) begin
            ref_nx_o     = gap_i;
            st_nx_o.seen = 1'b1;
         end else if (gap_i != ref_q) begin
            st_nx_o.differ = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= '0;
         st_q  <= '0;
      end else if (clear_i) begin
         ref_q <= '0;
         st_q  <= '0;
      end else begin
         ref_q <= ref_nx_o;
         st_q  <= st_nx_o;
      end
   end

endmodule

// File: rtl/gce_latch.sv
module gce_latch
   import gce_pkg::*;
#(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         fire_i,
   input  logic [W-1:0] ref_nx_i,
   input  gce_track_t   st_nx_i,
   output logic         frozen_o,
   output logic         disagree_o,
   output logic [W-1:0] common_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frozen_o   <= 1'b0;
         disagree_o <= 1'b0;
         common_o   <= '0;
      end else if (clear_i) begin
         frozen_o   <= 1'b0;
         disagree_o <= 1'b0;
         common_o   <= '0;
      end else if (fire_i && !frozen_o) begin
         frozen_o   <= 1'b1;
         disagree_o <= st_nx_i.differ;
         common_o   <= (st_nx_i.seen && !st_nx_i.differ) ? ref_nx_i : '0;
      end
   end

endmodule

// File: rtl/gapcnt_agree_chk.sv
module gapcnt_agree_chk
   import gce_pkg::*;
#(
   parameter int GAP_W      = 6,
   parameter bit DONE_LEVEL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_reset_i,
   input  logic             sid_valid_i,
   input  logic [GAP_W-1:0] sid_gap_i,
   input  logic             sid_done_i,
   output logic             disagree_o,
   output logic [GAP_W-1:0] common_gap_o
);

   generate
      if (GAP_W < 1 || GAP_W > GCE_MAX_W) begin : g_bad_width
         $error("gapcnt_agree_chk: GAP_W out of range");
      end
   endgenerate

   logic             done_fire;
   logic             frozen;
   logic [GAP_W-1:0] ref_nx;
   gce_track_t       st_nx;

   gce_edge #(.LEVEL_IN(DONE_LEVEL)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (sid_done_i),
      .fire_o (done_fire)
   );

   gce_track #(.W(GAP_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (bus_reset_i),
      .hold_i   (frozen),
      .vld_i    (sid_valid_i),
      .gap_i    (sid_gap_i),
      .ref_nx_o (ref_nx),
      .st_nx_o  (st_nx)
   );

   gce_latch #(.W(GAP_W)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (bus_reset_i),
      .fire_i     (done_fire),
      .ref_nx_i   (ref_nx),
      .st_nx_i    (st_nx),
      .frozen_o   (frozen),
      .disagree_o (disagree_o),
      .common_o   (common_gap_o)
   );

endmodule

// File: rtl/gce_chk.sv
module gce_chk #(
   parameter int W = 6
) (
   input logic         clk,
   input logic         rst_n,
   input logic         bus_reset_i,
   input logic         sid_done_i,
   input logic         disagree_o,
   input logic [W-1:0] common_gap_o
);

   AST_BUSRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_i |=> (!disagree_o && common_gap_o == '0)); // R7

   AST_EXCLUSIVE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      disagree_o |-> (common_gap_o == '0)); // R3

   AST_HOLD_BETWEEN_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_reset_i && !$rose(sid_done_i)) |=> ($stable(disagree_o) && $stable(common_gap_o))); // R6

   AST_FLAG_ONLY_AT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disagree_o) |-> $past($rose(sid_done_i))); // R4

endmodule

bind gapcnt_agree_chk gce_chk #(.W(GAP_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_reset_i  (bus_reset_i),
   .sid_done_i   (sid_done_i),
   .disagree_o   (disagree_o),
   .common_gap_o (common_gap_o)
);

// File: tb/gapcnt_agree_chk_tb.sv
`timescale 1ns/1ps
module gapcnt_agree_chk_tb;

   localparam int W  = 6;
   localparam int NV = 7;

   // stimulus table: number of strobes and up to four gap values
   localparam int          VN [NV]    = '{3, 2, 0, 1, 4, 4, 3};
   localparam logic [W-1:0] VG [NV][4] = '{
      '{6'h3f, 6'h3f, 6'h3f, 6'h00},
      '{6'h05, 6'h06, 6'h00, 6'h00},
      '{6'h00, 6'h00, 6'h00, 6'h00},
      '{6'h0a, 6'h00, 6'h00, 6'h00},
      '{6'h10, 6'h10, 6'h10, 6'h11},
      '{6'h00, 6'h00, 6'h00, 6'h00},
      '{6'h21, 6'h07, 6'h21, 6'h00}};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_reset_i = 1'b0;
   logic         sid_valid_i = 1'b0;
   logic [W-1:0] sid_gap_i = '0;
   logic         sid_done_i = 1'b0;
   logic         disagree_o;
   logic [W-1:0] common_gap_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   gapcnt_agree_chk #(.GAP_W(W)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_reset_i  (bus_reset_i),
      .sid_valid_i  (sid_valid_i),
      .sid_gap_i    (sid_gap_i),
      .sid_done_i   (sid_done_i),
      .disagree_o   (disagree_o),
      .common_gap_o (common_gap_o)
   );

   task automatic chk(input string tag, input logic e_dis, input logic [W-1:0] e_gap);
      n_chk++;
      if (disagree_o !== e_dis || common_gap_o !== e_gap) begin
         n_bad++;
         $display("FAIL %s: got dis=%b gap=%h, expected dis=%b gap=%h",
                  tag, disagree_o, common_gap_o, e_dis, e_gap);
      end
   endtask

   task automatic pulse_busrst();
      @(negedge clk) bus_reset_i = 1'b1;
      @(negedge clk) bus_reset_i = 1'b0;
   endtask

   task automatic strobe(input logic [W-1:0] g);
      sid_valid_i = 1'b1; sid_gap_i = g;
      @(negedge clk) sid_valid_i = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset state", 1'b0, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic         e_dis;
         logic [W-1:0] e_gap;
         e_dis = 1'b0;
         for (int k = 1; k < VN[i]; k++)
            if (VG[i][k] != VG[i][0]) e_dis = 1'b1;
         e_gap = (VN[i] > 0 && !e_dis) ? VG[i][0] : '0;
         pulse_busrst();
         chk("R7 cleared by bus reset", 1'b0, '0);
         for (int k = 0; k < VN[i]; k++) begin
            strobe(VG[i][k]);
            chk("R9 quiet before freeze", 1'b0, '0);
         end
         sid_done_i = 1'b1;
         #1 chk("R4 no update before edge", 1'b0, '0);
         @(negedge clk);
         if (VN[i] == 0)   chk("R5 empty set", e_dis, e_gap);
         else if (e_dis)   chk("R3 disagreement", e_dis, e_gap);
         else              chk("R2 agreement", e_dis, e_gap);
         sid_done_i = 1'b0;
         @(negedge clk);
      end

      // R8: strobe on the same edge as the end rising edge
      pulse_busrst();
      strobe(6'h12);
      sid_valid_i = 1'b1; sid_gap_i = 6'h13; sid_done_i = 1'b1;
      @(negedge clk) sid_valid_i = 1'b0;
      chk("R8 same-cycle differing strobe", 1'b1, '0);
      sid_done_i = 1'b0;
      pulse_busrst();
      strobe(6'h12);
      sid_valid_i = 1'b1; sid_gap_i = 6'h12; sid_done_i = 1'b1;
      @(negedge clk) sid_valid_i = 1'b0;
      chk("R8 same-cycle matching strobe", 1'b0, 6'h12);
      sid_done_i = 1'b0;
      @(negedge clk);

      // R6: ignored after freeze
      strobe(6'h2d);
      chk("R6 strobe after freeze", 1'b0, 6'h12);
      sid_done_i = 1'b1;
      @(negedge clk);
      chk("R6 second end edge", 1'b0, 6'h12);
      sid_done_i = 1'b0;
      @(negedge clk);

      // R7: bus reset on the same edge as the end rising edge
      bus_reset_i = 1'b1; sid_done_i = 1'b1;
      @(negedge clk) bus_reset_i = 1'b0;
      chk("R7 reset beats end edge", 1'b0, '0);
      strobe(6'h07);
      chk("R7 no freeze while level held", 1'b0, '0);
      sid_done_i = 1'b0;
      @(negedge clk) sid_done_i = 1'b1;
      @(negedge clk);
      chk("R7 later freeze sees strobe", 1'b0, 6'h07);
      sid_done_i = 1'b0;
      @(negedge clk);

      // R1: asynchronous reset mid-run
      #1 rst_n = 1'b0;
      #1 chk("R1 async clear", 1'b0, '0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 1'b0, '0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule